// File: doc/BRIEF.md
# Pipelined Majority-Gate Magnitude Comparator

This block compares two unsigned N-bit operands and reports which one is larger, or that they match. It is built only from three-input majority functions and inverters, with no subtraction and no XOR equality tree. The operands are cut into small subwords of two or three bits. Each subword is judged on its own by two majority levels. The subword verdicts are then folded into a running prefix, starting at the least significant end, with one majority merge per subword.

Every majority level ends in a register, so the pipeline takes a new operand pair on every cycle and returns the verdict after a fixed latency. The "not less" output uses an inverted sense: it is 0 exactly when A is smaller than B. A plain "less" output is provided next to it. A valid flag travels alongside the data so that the consumer knows which output cycles carry results.

Top module: `maj_cmp_pipe`

## Requirements
- R1: When `valid_out` is 1, `cmp_gt` is 1 if and only if the unsigned operand A that produced it is greater than B.
- R2: When `valid_out` is 1, `cmp_nlt` is 0 if and only if A < B. For equal operands the pair (`cmp_gt`, `cmp_nlt`) is (0, 1). `cmp_gt` = 1 always implies `cmp_nlt` = 1.
- R3: When `valid_out` is 1, `cmp_eq` is 1 if and only if A == B.
- R4: `cmp_lt` is the inverse of `cmp_nlt`, so it is 1 if and only if A < B.
- R5: Let S be the number of subwords. The lowest one or two subwords are 2 bits wide (one when N mod 3 = 2, two when N mod 3 = 1, none when N mod 3 = 0) and all others are 3 bits wide. A pair sampled with `valid_in` = 1 at a rising edge appears, with `valid_out` = 1, S+3 rising edges later, counting the sampling edge. This gives 14 for N = 32 and 5 for N = 4.
- R6: A new operand pair can be accepted on every cycle. Back-to-back pairs give independent results on consecutive cycles.
- R7: A synchronous reset (`rst` = 1 at a rising edge) forces `valid_out` to 0 from that edge on, and drops every pair still in flight.
- R8: Whenever `valid_out` is 1, exactly one of `cmp_gt`, `cmp_lt` and `cmp_eq` is 1.
- R9: The most significant differing bit decides the result, whatever the lower bits hold. A single-bit difference at any position, including subword boundaries, yields the correct verdict.
- R10: A cycle with `valid_in` = 0 produces a cycle with `valid_out` = 0 at the matching output slot, with no effect on the neighbouring results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | N | Operand A, unsigned |
| b_in | input | N | Operand B, unsigned |
| valid_in | input | 1 | Marks the current operand pair as meaningful |
| cmp_gt | output | 1 | 1 when A > B |
| cmp_nlt | output | 1 | Inverted-sense flag, 0 when A < B |
| cmp_eq | output | 1 | 1 when A == B |
| cmp_lt | output | 1 | 1 when A < B |
| valid_out | output | 1 | Marks the output cycle of a pair that entered with valid_in |

## Verification
The embedded properties assume that `rst` is high from time zero through at least one rising edge, and that the operand inputs never carry unknown values. The data registers take whatever is on the operand pins on every cycle, valid or not, so an unknown bit would break the ordering property (gt implies not-less) and the merge properties. The stimulus holds reset from the start and always drives defined values on the operand pins, zeros during idle cycles. A mid-stream reset is applied only on a clock-aligned boundary.

// File: rtl/maj_cmp_pkg.sv
package maj_cmp_pkg;

    // Verdict of a comparison: gt = A>B, ge = A>=B (inverted-sense "B bigger").
    typedef struct packed {
        logic gt;
        logic ge;
    } cmp_pair_t;

    // Three-input majority, the only gate used for logic besides inversion.
    function automatic logic maj3(input logic p, input logic q, input logic r);
        return (p & q) | (p & r) | (q & r);
    endfunction

    // Number of 2-bit subwords placed at the least significant end.
    function automatic int low_pairs(input int n);
        if ((n % 3) == 1)
            return 2;
        else if ((n % 3) == 2)
            return 1;
        else
            return 0;
    endfunction

    function automatic int sub_count(input int n);
        return low_pairs(n) + (n - 2 * low_pairs(n)) / 3;
    endfunction

    function automatic int sub_width(input int n, input int i);
        return (i < low_pairs(n)) ? 2 : 3;
    endfunction

    function automatic int sub_base(input int n, input int i);
        if (i < low_pairs(n))
            return 2 * i;
        else
            return 2 * low_pairs(n) + 3 * (i - low_pairs(n));
    endfunction

endpackage

// File: rtl/maj_subword_stage.sv
module maj_subword_stage
    import maj_cmp_pkg::*;
#(
    parameter int W = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  a_i,
    input  logic [W-1:0]  b_i,
    output cmp_pair_t     res_o
);

    localparam int  TOP      = W - 1;
    localparam int  MID      = W - 2;
    localparam bit  HAS_LOW  = (W == 3);

    typedef struct packed {
        logic      x;
        logic      y;
        logic      t;
        logic      u;
        cmp_pair_t res;
    } sub_st_t;

    sub_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Level 1: pair terms on the two upper bits, plus the low-bit AND/OR.
        st_d.x = maj3(a_i[TOP], ~b_i[TOP], a_i[MID]);
        st_d.y = maj3(a_i[TOP], ~b_i[TOP], ~b_i[MID]);
        if (HAS_LOW) begin
            st_d.t = maj3(a_i[0], ~b_i[0], 1'b0);
            st_d.u = maj3(a_i[0], ~b_i[0], 1'b1);
        end else begin
            // A tie below a 2-bit subword: gt term 0, ge term 1.
            st_d.t = 1'b0;
            st_d.u = 1'b1;
        end
        // Level 2: fold the pair terms with the lower verdict.
        st_d.res.gt = maj3(st_q.x, st_q.y, st_q.t);
        st_d.res.ge = maj3(st_q.x, st_q.y, st_q.u);
        if (rst)
            st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign res_o = st_q.res;

    AST_SUB_ORDER: assert property (@(posedge clk) disable iff (rst)
        res_o.gt |-> res_o.ge)
        else $error("subword verdict claims gt without ge"); // R2

endmodule

// File: rtl/maj_merge_stage.sv
module maj_merge_stage
    import maj_cmp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  cmp_pair_t hi_i,
    input  cmp_pair_t lo_i,
    output cmp_pair_t res_o
);

    typedef struct packed {
        cmp_pair_t res;
    } mrg_st_t;

    mrg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.res.gt = maj3(hi_i.gt, hi_i.ge, lo_i.gt);
        st_d.res.ge = maj3(hi_i.gt, hi_i.ge, lo_i.ge);
        if (rst)
            st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign res_o = st_q.res;

    AST_MERGE_TIE_PASS: assert property (@(posedge clk) disable iff (rst)
        (!hi_i.gt && hi_i.ge) |=> (res_o == $past(lo_i)))
        else $error("tied upper part did not pass lower verdict"); // R9

    AST_MERGE_HI_DECIDES: assert property (@(posedge clk) disable iff (rst)
        (hi_i.gt == hi_i.ge) |=> (res_o == $past(hi_i)))
        else $error("decisive upper part was overridden"); // R9

endmodule

// File: rtl/maj_pair_delay.sv
module maj_pair_delay
    import maj_cmp_pkg::*;
#(
    parameter int DEPTH = 1
) (
    input  logic      clk,
    input  logic      rst,
    input  cmp_pair_t d_i,
    output cmp_pair_t q_o
);

    typedef struct packed {
        cmp_pair_t [DEPTH-1:0] sh;
    } dly_st_t;

    dly_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.sh[0] = d_i;
        for (int k = 1; k < DEPTH; k++) begin
            st_d.sh[k] = st_q.sh[k-1];
        end
        if (rst)
            st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q_o = st_q.sh[DEPTH-1];

endmodule

// File: rtl/maj_cmp_pipe.sv
module maj_cmp_pipe
    import maj_cmp_pkg::*;
#(
    parameter int N = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  a_in,
    input  logic [N-1:0]  b_in,
    input  logic          valid_in,
    output logic          cmp_gt,
    output logic          cmp_nlt,
    output logic          cmp_eq,
    output logic          cmp_lt,
    output logic          valid_out
);

    localparam int NS  = sub_count(N);
    localparam int LAT = NS + 3;

    typedef struct packed {
        logic [N-1:0]   a;
        logic [N-1:0]   b;
        logic [LAT-1:0] vld;
        logic           gt;
        logic           ge;
        logic           eq;
    } top_st_t;

    top_st_t   st_d, st_q;
    cmp_pair_t pfx [NS];

    // Subword judges and the least-to-most significant merge cascade.
    for (genvar i = 0; i < NS; i++) begin : g_sub
        localparam int SW = sub_width(N, i);
        localparam int SB = sub_base(N, i);

        cmp_pair_t sr;

        maj_subword_stage #(.W(SW)) u_sub (
            .clk   (clk),
            .rst   (rst),
            .a_i   (st_q.a[SB +: SW]),
            .b_i   (st_q.b[SB +: SW]),
            .res_o (sr)
        );

        if (i == 0) begin : g_first
            assign pfx[0] = sr;
        end else begin : g_chain
            cmp_pair_t hi;

            if (i >= 2) begin : g_dly
                maj_pair_delay #(.DEPTH(i - 1)) u_dly (
                    .clk (clk),
                    .rst (rst),
                    .d_i (sr),
                    .q_o (hi)
                );
            end else begin : g_nodly
                assign hi = sr;
            end

            maj_merge_stage u_mrg (
                .clk   (clk),
                .rst   (rst),
                .hi_i  (hi),
                .lo_i  (pfx[i-1]),
                .res_o (pfx[i])
            );
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.a   = a_in;
        st_d.b   = b_in;
        st_d.vld = {st_q.vld[LAT-2:0], valid_in};
        st_d.gt  = pfx[NS-1].gt;
        st_d.ge  = pfx[NS-1].ge;
        st_d.eq  = maj3(~pfx[NS-1].gt, pfx[NS-1].ge, 1'b0);
        if (rst)
            st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cmp_gt    = st_q.gt;
    assign cmp_nlt   = st_q.ge;
    assign cmp_eq    = st_q.eq;
    assign cmp_lt    = ~st_q.ge;
    assign valid_out = st_q.vld[LAT-1];

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        valid_out |-> ($countones({cmp_gt, cmp_lt, cmp_eq}) == 1))
        else $error("verdict is not exactly one of gt/lt/eq"); // R8

    AST_RESET_FLUSH: assert property (@(posedge clk)
        rst |=> !valid_out)
        else $error("valid survived a reset edge"); // R7

endmodule

// File: tb/tb_maj_cmp_pipe.sv
module tb_maj_cmp_pipe;

    localparam int CLK_PERIOD = 10;
    localparam int LAT32      = 14;   // R5: 11 subwords + 3
    localparam int LAT4       = 5;    // R5: 2 subwords + 3

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] a32 = '0, b32 = '0;
    logic        v32 = 1'b0;
    logic [3:0]  a4 = '0, b4 = '0;
    logic        v4 = 1'b0;

    logic gt32, nlt32, eq32, lt32, vo32;
    logic gt4, nlt4, eq4, lt4, vo4;

    int    checks = 0;
    int    errors = 0;
    string scn    = "R7 reset";

    logic [31:0] ha [LAT32];
    logic [31:0] hb [LAT32];
    logic        hv [LAT32];
    logic [3:0]  sa [LAT4];
    logic [3:0]  sb [LAT4];
    logic        sv [LAT4];
    logic [31:0] ea, eb;
    logic [3:0]  fa, fb;

    always #(CLK_PERIOD / 2) clk = ~clk;

    maj_cmp_pipe #(.N(32)) dut (
        .clk(clk), .rst(rst), .a_in(a32), .b_in(b32), .valid_in(v32),
        .cmp_gt(gt32), .cmp_nlt(nlt32), .cmp_eq(eq32), .cmp_lt(lt32), .valid_out(vo32)
    );

    maj_cmp_pipe #(.N(4)) dut4 (
        .clk(clk), .rst(rst), .a_in(a4), .b_in(b4), .valid_in(v4),
        .cmp_gt(gt4), .cmp_nlt(nlt4), .cmp_eq(eq4), .cmp_lt(lt4), .valid_out(vo4)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s [%s] t=%0t actual %0h expected %0h", req, scn, $time, act, exp);
        end
    endtask

    // Reference model: history of driven inputs, checked LAT edges later.
    always @(negedge clk) begin
        if (rst) begin
            for (int k = 0; k < LAT32; k++) hv[k] = 1'b0;
            for (int k = 0; k < LAT4; k++)  sv[k] = 1'b0;
        end else begin
            chk("R5/R10 valid N32", 32'(vo32), 32'(hv[LAT32-1]));
            if (hv[LAT32-1]) begin
                ea = ha[LAT32-1];
                eb = hb[LAT32-1];
                chk("R1 gt N32",  32'(gt32),  32'(ea > eb));
                chk("R2 nlt N32", 32'(nlt32), 32'(!(ea < eb)));
                chk("R3 eq N32",  32'(eq32),  32'(ea == eb));
                chk("R4 lt N32",  32'(lt32),  32'(ea < eb));
                chk("R8 one N32", 32'($countones({gt32, lt32, eq32})), 32'd1);
            end
            chk("R5/R10 valid N4", 32'(vo4), 32'(sv[LAT4-1]));
            if (sv[LAT4-1]) begin
                fa = sa[LAT4-1];
                fb = sb[LAT4-1];
                chk("R1 gt N4",  32'(gt4),  32'(fa > fb));
                chk("R2 nlt N4", 32'(nlt4), 32'(!(fa < fb)));
                chk("R3 eq N4",  32'(eq4),  32'(fa == fb));
                chk("R4 lt N4",  32'(lt4),  32'(fa < fb));
            end
            for (int k = LAT32 - 1; k > 0; k--) begin
                ha[k] = ha[k-1]; hb[k] = hb[k-1]; hv[k] = hv[k-1];
            end
            ha[0] = a32; hb[0] = b32; hv[0] = v32;
            for (int k = LAT4 - 1; k > 0; k--) begin
                sa[k] = sa[k-1]; sb[k] = sb[k-1]; sv[k] = sv[k-1];
            end
            sa[0] = a4; sb[0] = b4; sv[0] = v4;
        end
    end

    task automatic put32(input logic [31:0] a, input logic [31:0] b, input logic v);
        @(posedge clk);
        #1;
        a32 = v ? a : '0;
        b32 = v ? b : '0;
        v32 = v;
        a4 = '0; b4 = '0; v4 = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) put32('0, '0, 1'b0);
    endtask

    task automatic t_reset_state();
        scn = "R7 reset state";
        repeat (3) @(posedge clk);
        #1;
        chk("R7 valid N32 in reset", 32'(vo32), 32'd0);
        chk("R7 valid N4 in reset",  32'(vo4),  32'd0);
        rst = 1'b0;
        idle(LAT32 + 2);
    endtask

    task automatic t_equal();
        scn = "R3 equal operands";
        put32(32'h0, 32'h0, 1'b1);
        put32(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
        for (int k = 0; k < 20; k++) begin
            logic [31:0] r;
            r = $urandom;
            put32(r, r, 1'b1);
        end
        idle(LAT32 + 2);
    endtask

    task automatic t_single_bit();
        scn = "R9 single-bit difference";
        for (int i = 0; i < 32; i++) begin
            logic [31:0] base, bit_m;
            base  = $urandom;
            bit_m = 32'h1 << i;
            put32(base | bit_m, base & ~bit_m, 1'b1);
            put32(base & ~bit_m, base | bit_m, 1'b1);
        end
        put32(32'h8000_0000, 32'h7FFF_FFFF, 1'b1);
        put32(32'h7FFF_FFFF, 32'h8000_0000, 1'b1);
        idle(LAT32 + 2);
    endtask

    task automatic t_random();
        scn = "R1 R2 R4 random";
        for (int k = 0; k < 400; k++) begin
            put32($urandom, $urandom, 1'b1);
        end
        idle(LAT32 + 2);
    endtask

    task automatic t_back_to_back();
        scn = "R6 back-to-back mixed verdicts";
        for (int k = 0; k < 30; k++) begin
            logic [31:0] r;
            r = $urandom | 32'h2;
            case (k % 3)
                0:       put32(r, r - 1, 1'b1);
                1:       put32(r - 1, r, 1'b1);
                default: put32(r, r, 1'b1);
            endcase
        end
        idle(LAT32 + 2);
    endtask

    task automatic t_bubbles();
        scn = "R10 bubbles";
        for (int k = 0; k < 40; k++) begin
            put32($urandom, $urandom, (k % 3) != 1);
        end
        idle(LAT32 + 2);
    endtask

    task automatic t_exhaustive4();
        scn = "R1 R2 R3 R4 exhaustive N4";
        for (int ia = 0; ia < 16; ia++) begin
            for (int ib = 0; ib < 16; ib++) begin
                @(posedge clk);
                #1;
                a32 = '0; b32 = '0; v32 = 1'b0;
                a4 = 4'(ia); b4 = 4'(ib); v4 = 1'b1;
            end
        end
        idle(LAT32 + 2);
    endtask

    task automatic t_mid_reset();
        scn = "R7 mid-stream reset";
        for (int k = 0; k < 6; k++) put32($urandom, $urandom, 1'b1);
        @(posedge clk);
        #1;
        rst = 1'b1;
        v32 = 1'b0; a32 = '0; b32 = '0;
        @(posedge clk);
        #1;
        chk("R7 valid N32 after reset edge", 32'(vo32), 32'd0);
        chk("R7 valid N4 after reset edge",  32'(vo4),  32'd0);
        @(posedge clk);
        #1;
        rst = 1'b0;
        idle(LAT32 + 2);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL R5 watchdog expired t=%0t actual running expected finished", $time);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < LAT32; k++) begin ha[k] = '0; hb[k] = '0; hv[k] = 1'b0; end
        for (int k = 0; k < LAT4; k++)  begin sa[k] = '0; sb[k] = '0; sv[k] = 1'b0; end
        t_reset_state();
        t_equal();
        t_single_bit();
        t_random();
        t_back_to_back();
        t_bubbles();
        t_exhaustive4();
        t_mid_reset();
        t_random();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule